// File: doc/BRIEF.md
# Two-Row Associative Read Cache

This block sits between a slow peripheral bus and a burst-capable DDR memory transaction controller. It keeps two independent rows. Each row holds one 8-byte-aligned region under its own tag, and either row may hold any region. A byte read that matches a valid row is answered straight from that row, and the memory sees no transaction. A read that matches no row starts one linear burst of four 16-bit words. The burst refills the least recently used row, and the requested byte is returned once the row is complete.

Byte writes travelling to memory on another path are snooped. When a write falls inside a valid row, that row's copy of the byte is updated, so later hits return the new value. When the enable input is low, every read becomes its own single-word transaction and both rows are dropped. This lets software compare cached and uncached behaviour, or bypass the rows for regions that must not be held.

Top module: `tworow_rdcache`

## Requirements
- R1: Each of the two rows can hold any 8-byte-aligned region. Two different regions, read one after the other, both stay resident, and later reads of either region hit.
- R2: A read with the enable high that matches no valid row raises `memReq` for exactly one cycle, with `memBurst`=1 and `memAddr` equal to the read address with its low three bits cleared. The memory then returns four words. Word k carries byte base+2k in bits 15:8 and byte base+2k+1 in bits 7:0.
- R3: A read that hits a valid row asserts `rdValid` on the first clock edge after the edge that samples `rdReq`, and raises no `memReq`.
- R4: After a miss, `rdValid` rises on the second clock edge after the edge that takes the fourth word. `rdData` is then the byte of the row selected by address bits 2..0.
- R5: On a miss, the row replaced is the one used less recently. Both a hit and a completed fill mark a row as most recently used.
- R6: With `cacheEn` low, each read raises `memReq` with `memBurst`=0 and `memAddr` equal to the address with bit 0 cleared, and takes a single word. `rdValid` rises on the edge after the edge that takes that word, with bits 15:8 returned for an even address and bits 7:0 for an odd one. Both rows are invalidated, so after the enable is raised again the first read of a previously cached region misses.
- R7: A `wrReq` whose address lies inside a valid row replaces that byte of the row, and a later read of it hits and returns the new value. A write outside both rows changes neither row.
- R8: After reset, `rdValid` and `memReq` are low and both rows are invalid, so the first read misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cacheEn | input | 1 | 1: rows in use; 0: pass-through, rows dropped |
| rdReq | input | 1 | One-cycle byte read request |
| wrReq | input | 1 | One-cycle byte write snoop |
| addr | input | ADDR_W | Byte address of the read or write |
| wrData | input | 8 | Byte being written |
| rdData | output | 8 | Returned byte, valid with rdValid |
| rdValid | output | 1 | One-cycle read completion strobe |
| memReq | output | 1 | One-cycle memory transaction request |
| memBurst | output | 1 | 1: four-word linear burst; 0: single word |
| memAddr | output | ADDR_W | Byte address of the first word |
| memWord | input | 16 | Word returned by memory |
| memWordValid | input | 1 | Qualifies memWord, one word per cycle |

## Verification
The assertions take it for granted that a read is issued only when none is outstanding, and that no write arrives while a fill is in progress. They also assume the enable is held steady from a read request until its answer, and that the memory returns exactly the number of words the request implies. The bench's task-driven reads wait for `rdValid` before issuing anything else. Writes and enable changes happen only between reads, and the memory model responds with a fixed latency and word count per transaction, so the stimulus never leaves that envelope.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int LINE_BYTES = 8;
  localparam int LINE_WORDS = LINE_BYTES / 2;
  localparam int WIDX_W     = $clog2(LINE_WORDS);
  localparam int OFF_W      = $clog2(LINE_BYTES);

  typedef struct packed {
    logic              latch;
    logic              startFill;
    logic              hitResp;
    logic              fillWord;
    logic [WIDX_W-1:0] wordIdx;
    logic              fillDone;
    logic              lineResp;
    logic              passResp;
  } rcStrobe_t;
endpackage

// File: rtl/rc_datapath.sv
module rc_datapath
  import rc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheEn,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [15:0]       memWord,
  input  rcStrobe_t         strb,
  output logic              hit,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        rdData,
  output logic              rdValid
);
  localparam int NROWS = 2;
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [7:0]       rowData [NROWS][LINE_BYTES];
  logic [TAG_W-1:0] rowTag  [NROWS];
  logic [NROWS-1:0] rowValid;
  logic [NROWS-1:0] rowHit;
  logic [NROWS-1:0] wrHit;
  logic             lru;
  logic             fillRow;
  logic             hitRow;
  logic [TAG_W-1:0] addrTag;
  logic [OFF_W-1:0] addrOff;
  logic [OFF_W-1:0] fillOff;

  assign addrTag = addr[ADDR_W-1:OFF_W];
  assign addrOff = addr[OFF_W-1:0];
  assign fillOff = {strb.wordIdx, 1'b0};

  for (genvar r = 0; r < NROWS; r++) begin : g_cmp
    assign rowHit[r] = cacheEn && rowValid[r] && (rowTag[r] == addrTag);
    assign wrHit[r]  = wrReq && rowValid[r] && (rowTag[r] == addrTag);
  end

  assign hit    = |rowHit;
  assign hitRow = rowHit[1];

  // Row storage and tags: no reset, validity guards their use.
  always_ff @(posedge clk) begin
    for (int r = 0; r < NROWS; r++) begin
      if (strb.fillWord && (fillRow == r[0])) begin
        rowData[r][fillOff]        <= memWord[15:8];
        rowData[r][fillOff + 1'b1] <= memWord[7:0];
      end
      if (wrHit[r]) rowData[r][addrOff] <= wrData;
      if (strb.startFill && (lru == r[0])) rowTag[r] <= addrTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowValid <= '0;
      lru      <= 1'b0;
      fillRow  <= 1'b0;
      rdValid  <= 1'b0;
      rdData   <= '0;
      reqAddr  <= '0;
    end else begin
      rdValid <= 1'b0;
      if (strb.latch) begin
        reqAddr <= addr;
        fillRow <= lru;
      end
      if (strb.startFill) rowValid[lru] <= 1'b0;
      if (strb.hitResp) begin
        rdValid <= 1'b1;
        rdData  <= rowData[hitRow][addrOff];
        lru     <= ~hitRow;
      end
      if (strb.fillDone) begin
        rowValid[fillRow] <= 1'b1;
        lru               <= ~fillRow;
      end
      if (strb.lineResp) begin
        rdValid <= 1'b1;
        rdData  <= rowData[fillRow][reqAddr[OFF_W-1:0]];
      end
      if (strb.passResp) begin
        rdValid <= 1'b1;
        rdData  <= reqAddr[0] ? memWord[7:0] : memWord[15:8];
      end
      if (!cacheEn) rowValid <= '0;
    end
  end

  // R1
  rows_distinct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rowValid == 2'b11) |-> (rowTag[0] != rowTag[1]));
endmodule

// File: rtl/rc_control.sv
module rc_control
  import rc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cacheEn,
  input  logic      rdReq,
  input  logic      hit,
  input  logic      memWordValid,
  output rcStrobe_t strb,
  output logic      memReq,
  output logic      memBurst
);
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_RESP, ST_PASS} rcState_t;

  rcState_t          state, stateNext;
  logic [WIDX_W-1:0] wordCnt;
  logic              startTx;

  assign startTx = (state == ST_IDLE) && rdReq && !hit;

  always_comb begin
    strb         = '0;
    strb.wordIdx = wordCnt;
    stateNext    = state;
    unique case (state)
      ST_IDLE: begin
        if (rdReq) begin
          if (hit) begin
            strb.hitResp = 1'b1;
          end else begin
            strb.latch = 1'b1;
            if (cacheEn) begin
              strb.startFill = 1'b1;
              stateNext      = ST_FILL;
            end else begin
              stateNext = ST_PASS;
            end
          end
        end
      end
      ST_FILL: begin
        if (memWordValid) begin
          strb.fillWord = 1'b1;
          if (wordCnt == WIDX_W'(LINE_WORDS - 1)) begin
            strb.fillDone = 1'b1;
            stateNext     = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        strb.lineResp = 1'b1;
        stateNext     = ST_IDLE;
      end
      ST_PASS: begin
        if (memWordValid) begin
          strb.passResp = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wordCnt  <= '0;
      memReq   <= 1'b0;
      memBurst <= 1'b0;
    end else begin
      state  <= stateNext;
      memReq <= startTx;
      if (startTx) begin
        memBurst <= cacheEn;
        wordCnt  <= '0;
      end else if (strb.fillWord) begin
        wordCnt <= wordCnt + 1'b1;
      end
    end
  end

  // R2
  memreq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R3
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && rdReq && hit) |=> !memReq);

  // R6
  pass_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memBurst == $past(cacheEn)));
endmodule

// File: rtl/tworow_rdcache.sv
module tworow_rdcache
  import rc_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheEn,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              memReq,
  output logic              memBurst,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [15:0]       memWord,
  input  logic              memWordValid
);
  rcStrobe_t         strb;
  logic              hit;
  logic [ADDR_W-1:0] reqAddr;

  rc_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cacheEn     (cacheEn),
    .rdReq       (rdReq),
    .hit         (hit),
    .memWordValid(memWordValid),
    .strb        (strb),
    .memReq      (memReq),
    .memBurst    (memBurst)
  );

  rc_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cacheEn(cacheEn),
    .wrReq  (wrReq),
    .addr   (addr),
    .wrData (wrData),
    .memWord(memWord),
    .strb   (strb),
    .hit    (hit),
    .reqAddr(reqAddr),
    .rdData (rdData),
    .rdValid(rdValid)
  );

  assign memAddr = memBurst ? {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                            : {reqAddr[ADDR_W-1:1], 1'b0};
endmodule

// File: tb/tworow_rdcache_test.sv
module tworow_rdcache_test;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cacheEn = 1'b1;
  logic          rdReq = 1'b0;
  logic          wrReq = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wrData = '0;
  logic [7:0]    rdData;
  logic          rdValid;
  logic          memReq;
  logic          memBurst;
  logic [AW-1:0] memAddr;
  logic [15:0]   memWord = '0;
  logic          memWordValid = 1'b0;

  always #2.5 clk = ~clk;

  tworow_rdcache #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .rdReq(rdReq), .wrReq(wrReq),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .memReq(memReq), .memBurst(memBurst), .memAddr(memAddr),
    .memWord(memWord), .memWordValid(memWordValid)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  logic [7:0] mem [1024];
  int         txCount = 0;
  logic [AW-1:0] lastAddr = '0;
  logic       lastBurst = 1'b0;
  int         lastWordCyc = 0;
  int         wordsLeft = 0;
  int         delayLeft = 0;
  logic [AW-1:0] nextAddr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model: fixed latency, one word per cycle, driven away from the edge.
  always @(negedge clk) begin
    memWordValid = 1'b0;
    if (memReq) begin
      txCount++;
      lastAddr  = memAddr;
      lastBurst = memBurst;
      nextAddr  = memAddr;
      wordsLeft = memBurst ? 4 : 1;
      delayLeft = 2;
    end else if (wordsLeft > 0) begin
      if (delayLeft > 0) begin
        delayLeft--;
      end else begin
        memWord      = {mem[nextAddr[9:0]], mem[nextAddr[9:0] + 10'd1]};
        memWordValid = 1'b1;
        nextAddr     = nextAddr + 2;
        wordsLeft--;
        lastWordCyc  = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one read and check data, transaction behaviour and timing.
  task automatic doRead(input logic [AW-1:0] a, input bit expMiss, input string req);
    int txBefore;
    int lat;
    bit passMode;
    passMode = !cacheEn;
    txBefore = txCount;
    @(negedge clk);
    addr  = a;
    rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
    lat = 1;
    while (!rdValid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk(rdValid == 1'b1, req, rdValid, 1);
    chk(rdData == mem[a[9:0]], req, rdData, mem[a[9:0]]);
    if (!expMiss) begin
      // R3: hit answers on the next edge with no memory transaction
      chk(txCount == txBefore, {req, " R3 no tx"}, txCount - txBefore, 0);
      chk(lat == 1, {req, " R3 latency"}, lat, 1);
    end else if (passMode) begin
      // R6: single-word transaction, even address, answered one edge later
      chk(txCount == txBefore + 1, {req, " R6 tx"}, txCount - txBefore, 1);
      chk(lastBurst == 1'b0, {req, " R6 burst"}, lastBurst, 0);
      chk(lastAddr == {a[AW-1:1], 1'b0}, {req, " R6 addr"}, lastAddr, {a[AW-1:1], 1'b0});
      chk(cyc - lastWordCyc == 1, {req, " R6 timing"}, cyc - lastWordCyc, 1);
    end else begin
      // R2: one burst from the aligned base; R4: answer two edges after last word
      chk(txCount == txBefore + 1, {req, " R2 tx"}, txCount - txBefore, 1);
      chk(lastBurst == 1'b1, {req, " R2 burst"}, lastBurst, 1);
      chk(lastAddr == {a[AW-1:3], 3'b000}, {req, " R2 addr"}, lastAddr, {a[AW-1:3], 3'b000});
      chk(cyc - lastWordCyc == 2, {req, " R4 timing"}, cyc - lastWordCyc, 2);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr   = a;
    wrData = d;
    wrReq  = 1'b1;
    mem[a[9:0]] = d;
    @(negedge clk);
    wrReq = 1'b0;
  endtask

  // Vector: {address[15:0], expect miss}. Regions A=0x100, B=0x208, C=0x310.
  localparam logic [16:0] VEC [10] = '{
    {16'h0103, 1'b1},  // A miss (R8 first read after reset)
    {16'h0105, 1'b0},  // A hit
    {16'h0208, 1'b1},  // B miss
    {16'h0107, 1'b0},  // A still resident (R1)
    {16'h020E, 1'b0},  // B still resident (R1)
    {16'h0311, 1'b1},  // C miss, evicts A (R5)
    {16'h020A, 1'b0},  // B kept (R5)
    {16'h0100, 1'b1},  // A miss, evicts C (R5)
    {16'h0314, 1'b1},  // C miss, evicts B (R5)
    {16'h0101, 1'b0}   // A hit (R5)
  };

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(rdValid == 1'b0, "R8 rdValid", rdValid, 0);
    chk(memReq == 1'b0, "R8 memReq", memReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdValid == 1'b0 && memReq == 1'b0, "R8 idle after reset", {rdValid, memReq}, 0);

    for (int v = 0; v < 10; v++) begin
      doRead({8'h00, VEC[v][16:1]}, VEC[v][0], $sformatf("R1/R5 vec%0d", v));
    end

    // R7: write inside resident region A updates the row
    doWrite(24'h000102, 8'hC3);
    doRead(24'h000102, 1'b0, "R7 snooped byte");
    doRead(24'h000106, 1'b0, "R7 neighbour untouched");
    // R7: write outside both rows leaves rows alone
    doWrite(24'h000380, 8'h3C);
    doRead(24'h000104, 1'b0, "R7 row A intact");
    doRead(24'h000315, 1'b0, "R7 row C intact");
    doRead(24'h000380, 1'b1, "R7 uncached write then miss");

    // R6: pass-through mode
    @(negedge clk);
    cacheEn = 1'b0;
    doRead(24'h000101, 1'b1, "R6 odd byte");
    doRead(24'h000102, 1'b1, "R6 even byte");
    @(negedge clk);
    cacheEn = 1'b1;
    doRead(24'h000103, 1'b1, "R6 rows dropped");
    doRead(24'h000104, 1'b0, "R6 refill hit");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (!finished && cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule